// File: doc/BRIEF.md
# Register-mapped countdown event timer

This block is a countdown timer that runs on the system clock. Software reaches it through a single-cycle register port with 32-bit words on 4-byte boundaries. Software first clears the run bit. It then writes a start count, and a restart count if one is needed, and sets the run bit again. From then on the count drops by one on each clock.

When the count reaches zero, the timer flags an event. The restart count sets the mode. A restart count of zero makes the timer one-shot: the count stays at zero. A non-zero restart count makes the timer periodic: the count restarts from that value.

The live count is not readable directly. Any write to the capture register copies the count into a snapshot register, and reads return the snapshot. The zero event feeds a small interrupt block made of three registers:
- a raw state bit;
- a latched pending bit, cleared by writing 1 to it;
- a mask bit.

The interrupt line is driven from the pending and mask bits.

Top module: `evt_timer`

## Requirements
- R1: After reset the start, restart, run, mask, pending and snapshot registers all read 0. The state register reads 1, because the count is zero. `irq_o` is low.
- R2: While run (offset 0x08, bit 0) is 0, the count takes the start register (offset 0x00) value on every clock. The first clock with run set decrements from that value.
- R3: While run is 1 and the count is non-zero, the count decreases by exactly one per clock.
- R4: While run is 1 and the count is zero, the next count is the restart register (offset 0x04). A restart of 0 holds the count at zero (one-shot). A non-zero restart R repeats the zero state every R+1 clocks.
- R5: Bit 0 of the state register (offset 0x14) reads 1 exactly when the count is zero.
- R6: Pending bit 0 (offset 0x18) sets on the clock after the count enters zero while run is 1. A set in the same cycle as a clear wins.
- R7: Writing 1 to pending bit 0 clears it. Writing 0 leaves it unchanged.
- R8: `irq_o` is high exactly when pending bit 0 and mask bit 0 (offset 0x1C) are both 1.
- R9: A write of any data to offset 0x0C copies the count, as it stands before that clock edge, into the snapshot register. Reads of offset 0x10 return the snapshot.
- R10: `addr_i` is a byte address, and `addr_i[4:2]` selects one of the eight words. Accesses with `addr_i[1:0]` non-zero, or with address bits above bit 4 set, are ignored.
- R11: Read data appears on `rdata_o` for one cycle after the read request and is 0 otherwise. Offset 0x0C reads 0. Writes to the snapshot and state registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request, one cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte address within the window |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, one cycle after a read request |
| irq_o | output | 1 | Zero-event interrupt |

## Verification
The bench starts by snapshotting the count in the first cycles after run is set. A design that decremented one clock late, or captured the count after the edge, returns a snapshot that is off by one.

It then exercises the one-shot case. A design that kept reloading or re-raising the event would set pending again after software cleared it.

It runs a periodic case with the mask off. A design that let the interrupt line skip the mask would raise `irq_o` there.

It also checks the clear rules. Pending must stay set after a zero is written to it. Writes to the read-only registers must leave their contents unchanged.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  // word index = addr[4:2]; order fixes the software-visible map
  typedef enum logic [2:0] {
    SEL_START   = 3'd0,
    SEL_RESTART = 3'd1,
    SEL_RUN     = 3'd2,
    SEL_CAPTURE = 3'd3,
    SEL_SNAP    = 3'd4,
    SEL_STATE   = 3'd5,
    SEL_PEND    = 3'd6,
    SEL_MASK    = 3'd7
  } reg_sel_e;

  localparam int unsigned WinBits = 5;
endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [WIDTH-1:0]  start_o,
  output logic [WIDTH-1:0]  restart_o,
  output logic              run_o,
  output logic              mask_o,
  output logic              capture_o,
  output logic              pend_clr_o,
  input  logic [WIDTH-1:0]  snap_i,
  input  logic              zero_i,
  input  logic              pend_i
);
  logic     in_win;
  logic     wr, rd;
  reg_sel_e sel;

  generate
    if (ADDR_W > WinBits) begin : g_hi
      assign in_win = (addr_i[ADDR_W-1:WinBits] == '0) && (addr_i[1:0] == 2'b00);
    end else begin : g_nohi
      assign in_win = (addr_i[1:0] == 2'b00);
    end
  endgenerate

  assign sel = reg_sel_e'(addr_i[4:2]);
  assign wr  = req_i & we_i & in_win;
  assign rd  = req_i & ~we_i & in_win;

  logic [WIDTH-1:0] start_q, restart_q;
  logic             run_q, mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q   <= '0;
      restart_q <= '0;
      run_q     <= 1'b0;
      mask_q    <= 1'b0;
    end else if (wr) begin
      case (sel)
        SEL_START:   start_q   <= wdata_i[WIDTH-1:0];
        SEL_RESTART: restart_q <= wdata_i[WIDTH-1:0];
        SEL_RUN:     run_q     <= wdata_i[0];
        SEL_MASK:    mask_q    <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign capture_o  = wr && (sel == SEL_CAPTURE);
  assign pend_clr_o = wr && (sel == SEL_PEND) && wdata_i[0];

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    case (sel)
      SEL_START:   rd_mux = DATA_W'(start_q);
      SEL_RESTART: rd_mux = DATA_W'(restart_q);
      SEL_RUN:     rd_mux = DATA_W'(run_q);
      SEL_SNAP:    rd_mux = DATA_W'(snap_i);
      SEL_STATE:   rd_mux = DATA_W'(zero_i);
      SEL_PEND:    rd_mux = DATA_W'(pend_i);
      SEL_MASK:    rd_mux = DATA_W'(mask_q);
      default:     rd_mux = '0;
    endcase
  end

  logic [DATA_W-1:0] rdata_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
    else          rdata_q <= '0;
  end

  assign rdata_o   = rdata_q;
  assign start_o   = start_q;
  assign restart_o = restart_q;
  assign run_o     = run_q;
  assign mask_o    = mask_q;
endmodule

// File: rtl/evt_timer_cnt.sv
module evt_timer_cnt #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [WIDTH-1:0] start_i,
  input  logic [WIDTH-1:0] restart_i,
  input  logic             capture_i,
  output logic [WIDTH-1:0] cnt_o,
  output logic [WIDTH-1:0] snap_o,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt_q, cnt_d, snap_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    if (!run_i)       cnt_d = start_i;
    else if (at_zero) cnt_d = restart_i;  // restart 0 keeps zero: one-shot
    else              cnt_d = cnt_q - WIDTH'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      snap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (capture_i) snap_q <= cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;
  assign zero_o = at_zero;
endmodule

// File: rtl/evt_timer_evt.sv
module evt_timer_evt (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic zero_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic pend_o,
  output logic irq_o
);
  logic zero_q, pend_q, hit;

  assign hit = run_i & zero_i & ~zero_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_q <= 1'b1;  // count resets to zero: no edge out of reset
      pend_q <= 1'b0;
    end else begin
      zero_q <= zero_i;
      pend_q <= hit | (pend_q & ~clr_i);  // set beats clear
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q & mask_i;
endmodule

// File: rtl/evt_timer.sv
module evt_timer #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [WIDTH-1:0] start_w, restart_w, cnt_w, snap_w;
  logic             run_w, mask_w, capture_w, pend_clr_w, zero_w, pend_w;

  evt_timer_regs #(.WIDTH(WIDTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .start_o    (start_w),
    .restart_o  (restart_w),
    .run_o      (run_w),
    .mask_o     (mask_w),
    .capture_o  (capture_w),
    .pend_clr_o (pend_clr_w),
    .snap_i     (snap_w),
    .zero_i     (zero_w),
    .pend_i     (pend_w)
  );

  evt_timer_cnt #(.WIDTH(WIDTH)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_w),
    .start_i   (start_w),
    .restart_i (restart_w),
    .capture_i (capture_w),
    .cnt_o     (cnt_w),
    .snap_o    (snap_w),
    .zero_o    (zero_w)
  );

  evt_timer_evt u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_w),
    .zero_i (zero_w),
    .clr_i  (pend_clr_w),
    .mask_i (mask_w),
    .pend_o (pend_w),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int unsigned WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             irq_o,
  input logic             run,
  input logic             mask,
  input logic             pend,
  input logic             pend_clr,
  input logic             capture,
  input logic             zero,
  input logic [WIDTH-1:0] cnt,
  input logic [WIDTH-1:0] start,
  input logic [WIDTH-1:0] restart,
  input logic [WIDTH-1:0] snap
);
  p_follow_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> cnt == $past(start));

  p_decrement_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt != '0) |=> cnt == $past(cnt) - WIDTH'(1));

  p_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && cnt == '0) |=> cnt == $past(restart));

  p_state_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(zero) |-> $past(run) ? ($past(cnt) == '0) : 1'b1);

  p_pend_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && zero && !$past(zero)) |=> pend);

  p_pend_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_clr && !run) |=> !pend);

  p_pend_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && !pend_clr) |=> pend);

  p_irq_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend && mask));

  p_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture |=> snap == $past(cnt));
endmodule

bind evt_timer evt_timer_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irq_o    (irq_o),
  .run      (run_w),
  .mask     (mask_w),
  .pend     (pend_w),
  .pend_clr (pend_clr_w),
  .capture  (capture_w),
  .zero     (zero_w),
  .cnt      (cnt_w),
  .start    (start_w),
  .restart  (restart_w),
  .snap     (snap_w)
);

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  localparam int CLK_P = 10;
  localparam logic [4:0] A_START = 5'h00, A_RESTART = 5'h04, A_RUN = 5'h08,
                         A_CAPT = 5'h0C, A_SNAP = 5'h10, A_STATE = 5'h14,
                         A_PEND = 5'h18, A_MASK = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  evt_timer dut_i (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
  );

  // behavioural reference
  logic [31:0] m_start = 0, m_restart = 0, m_cnt = 0, m_snap = 0, m_rdata = 0;
  bit          m_run = 0, m_mask = 0, m_pend = 0, m_zprev = 1;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_start = 0; m_restart = 0; m_cnt = 0; m_snap = 0; m_rdata = 0;
      m_run = 0; m_mask = 0; m_pend = 0; m_zprev = 1;
    end else begin
      bit          z, acc, setp, clrp;
      logic [31:0] nxt, rv;
      z    = (m_cnt == 0);
      acc  = req && (addr[1:0] == 2'b00);
      setp = m_run && z && !m_zprev;
      clrp = acc && we && addr == A_PEND && wdata[0];
      if (!m_run) nxt = m_start;
      else if (z) nxt = m_restart;
      else        nxt = m_cnt - 1;
      case (addr)
        A_START:   rv = m_start;
        A_RESTART: rv = m_restart;
        A_RUN:     rv = {31'd0, m_run};
        A_SNAP:    rv = m_snap;
        A_STATE:   rv = {31'd0, z};
        A_PEND:    rv = {31'd0, m_pend};
        A_MASK:    rv = {31'd0, m_mask};
        default:   rv = 0;
      endcase
      m_rdata = (acc && !we) ? rv : 0;
      if (acc && we) begin
        case (addr)
          A_START:   m_start = wdata;
          A_RESTART: m_restart = wdata;
          A_RUN:     m_run = wdata[0];
          A_MASK:    m_mask = wdata[0];
          A_CAPT:    m_snap = m_cnt;
          default: ;
        endcase
      end
      m_pend  = setp || (m_pend && !clrp);
      m_zprev = z;
      m_cnt   = nxt;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R8 irq vs model", {31'd0, irq}, {31'd0, m_pend && m_mask});
      chk("R11 rdata vs model", rdata, m_rdata);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1; req = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1; req = 0; we = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1; req = 1; we = 0; addr = a;
    @(posedge clk); #1; req = 0;
    @(negedge clk); chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3); #1; rst_n = 1;
    @(negedge clk); chk("R1 irq after reset", {31'd0, irq}, 0);
    rd(A_START, 0, "R1 start");
    rd(A_RESTART, 0, "R1 restart");
    rd(A_RUN, 0, "R1 run");
    rd(A_SNAP, 0, "R1 snapshot");
    rd(A_PEND, 0, "R1 pending");
    rd(A_MASK, 0, "R1 mask");
    rd(A_STATE, 1, "R1 R5 state at zero");

    wr(A_START, 32'h1234);
    wr(A_RESTART, 32'h56);
    wr(A_MASK, 1);
    rd(A_START, 32'h1234, "R10 start map");
    rd(A_RESTART, 32'h56, "R10 restart map");
    rd(A_MASK, 1, "R10 mask map");
    rd(A_CAPT, 0, "R11 capture reads 0");
    wr(5'h01, 32'hFFFF);
    rd(A_START, 32'h1234, "R10 misaligned write ignored");

    wr(A_CAPT, 0);
    rd(A_SNAP, 32'h1234, "R2 count follows start while stopped");
    rd(A_STATE, 0, "R5 state nonzero");

    wr(A_RUN, 1);
    wr(A_CAPT, 0);
    rd(A_SNAP, 32'h1233, "R3 first run clock decrements");
    wr(A_CAPT, 0);
    rd(A_SNAP, 32'h122F, "R3 R9 one per clock");

    // one-shot
    wr(A_RUN, 0);
    wr(A_START, 20);
    wr(A_RESTART, 0);
    wr(A_PEND, 1);
    wr(A_RUN, 1);
    idle(40);
    rd(A_STATE, 1, "R5 state at zero");
    wr(A_CAPT, 0);
    rd(A_SNAP, 0, "R4 one-shot holds zero");
    rd(A_PEND, 1, "R6 pending set on zero");
    @(negedge clk); chk("R8 irq with mask", {31'd0, irq}, 1);
    wr(A_PEND, 0);
    rd(A_PEND, 1, "R7 write 0 no effect");
    wr(A_PEND, 1);
    rd(A_PEND, 0, "R7 write 1 clears");
    @(negedge clk); chk("R8 irq drops", {31'd0, irq}, 0);
    idle(20);
    rd(A_PEND, 0, "R4 R6 one-shot no new event");
    wr(A_SNAP, 32'hABCD);
    wr(A_STATE, 0);
    rd(A_SNAP, 0, "R11 snapshot write ignored");
    rd(A_STATE, 1, "R11 state write ignored");

    // periodic, masked
    wr(A_RUN, 0);
    wr(A_START, 4);
    wr(A_RESTART, 3);
    wr(A_MASK, 0);
    wr(A_PEND, 1);
    wr(A_RUN, 1);
    idle(20);
    rd(A_PEND, 1, "R4 periodic event");
    @(negedge clk); chk("R8 masked irq low", {31'd0, irq}, 0);
    wr(A_PEND, 1);
    idle(6);
    rd(A_PEND, 1, "R4 R6 periodic re-arms");
    repeat (12) begin
      wr(A_CAPT, 0);
      rd(A_SNAP, m_snap, "R9 periodic snapshot");
    end
    wr(A_MASK, 1);
    idle(10);
    @(negedge clk); chk("R8 unmasked irq", {31'd0, irq}, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule